// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block turns a 32-bit single-precision floating-point word into a 32-bit signed two's-complement integer, dropping any fractional part so that the result is rounded toward zero. A caller pulses `in_vld` with a word on `in_word`. Exactly one clock later, `out_vld` pulses and the integer and three status flags appear on the outputs. There is no back-pressure: each strobe yields one result.

The word is split into a sign, an 8-bit biased exponent and a 23-bit fraction. From the exponent field the block sorts the input into one of four classes: zero or subnormal, normal, infinity, or not-a-number. For a normal input the significand, with its hidden leading one, is shifted by the unbiased exponent to form the magnitude. The magnitude is then negated for negative inputs. Infinity, NaN and magnitudes that do not fit the signed range raise a flag and return the most negative integer.

Top module: `f2i_conv`

## Requirements
- R1: The input word is read as sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. A normal input (exponent field neither 0 nor 255) is converted with unbiased exponent = field - 127 and significand 1.fraction, and any fractional part is dropped (0x466DB400, which is 15213.0, gives 15213; 3.75 gives 3).
- R2: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high, and low otherwise. A synchronous active-high `rst` forces `out_vld` low, even if `in_vld` is high during reset.
- R3: An exponent field of 0 (+0, -0 and every subnormal) gives 0 with all flags low.
- R4: A normal input with unbiased exponent below 0 (magnitude under 1.0, either sign) gives 0 with all flags low.
- R5: A negative input gives the two's complement (bitwise inverse plus one) of its truncated magnitude, so -3.75 gives -3 (0xFFFFFFFD).
- R6: Exponent field 255 with fraction 0 (either sign) sets `out_inf` and gives 0x80000000.
- R7: Exponent field 255 with a nonzero fraction sets `out_nan` and gives 0x80000000.
- R8: A normal input whose truncated value lies outside [-2^31, 2^31-1] sets `out_ovf` and gives 0x80000000. The input exactly -2^31 (0xCF000000) gives 0x80000000 with no flag, and 0x4EFFFFFF gives 2147483520 with no flag.
- R9: At most one of `out_nan`, `out_inf`, `out_ovf` is high in any result.
- R10: Between strobes, `out_int` and the flags keep the value of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe, one conversion per high cycle |
| in_word | input | 32 | Single-precision floating-point word |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_int | output | 32 | Signed integer result, truncated toward zero |
| out_nan | output | 1 | Input was NaN |
| out_inf | output | 1 | Input was an infinity |
| out_ovf | output | 1 | Truncated value out of signed 32-bit range |

## Verification
On every cycle the assertions check the following:
- The strobe timing and the reset clearing of `out_vld`.
- That any raised flag comes with 0x80000000.
- That at most one flag is set.
- That a zero exponent field yields 0 with no flags.
- That a positive finite input never yields a negative unflagged integer.
- That results hold between strobes.

The exact integer for each input can only be shown by the bench's scenarios, compared against an independent 64-bit reference model. These include the 15213.0 example, fractions on both sides of zero, and the edges of the signed range (-2^31 exactly, the largest float below 2^31, and 2^31). They also include signed infinities, NaN, subnormals, back-to-back strobes and a pseudo-random sweep of exponents near the range limit.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    // Classes of an input word, decided from its exponent field.
    typedef enum logic [1:0] {
        FC_SUB  = 2'd0,   // zero or subnormal
        FC_NORM = 2'd1,
        FC_INF  = 2'd2,
        FC_NAN  = 2'd3
    } fp_class_e;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W-1:0] frac_o,
    output fp_class_e         cls_o
);
    always_comb begin
        sign_o = word_i[WORD_W-1];
        exp_o  = word_i[FRAC_W +: EXP_W];
        frac_o = word_i[FRAC_W-1:0];
        if (exp_o == '0)
            cls_o = FC_SUB;
        else if (exp_o == '1)
            cls_o = (frac_o == '0) ? FC_INF : FC_NAN;
        else
            cls_o = FC_NORM;
    end
endmodule

// File: rtl/f2i_magnitude.sv
module f2i_magnitude #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [INT_W-1:0]  mag_o,
    output logic              tiny_o,   // |value| < 1
    output logic              big_o,    // |value| >= 2^(INT_W-1)
    output logic              at_min_o  // |value| == 2^(INT_W-1) exactly
);
    localparam int EW = EXP_W + 2;
    localparam logic signed [EW-1:0] BIAS_S = EW'((2 ** (EXP_W - 1)) - 1);
    localparam logic signed [EW-1:0] TOP_S  = EW'(INT_W - 1);
    localparam logic signed [EW-1:0] FR_S   = EW'(FRAC_W);

    logic signed [EW-1:0] ue_s;
    logic [INT_W-1:0]     sig_w;

    always_comb begin
        ue_s     = $signed({2'b00, exp_i}) - BIAS_S;
        sig_w    = {{(INT_W - FRAC_W - 1){1'b0}}, 1'b1, frac_i};
        tiny_o   = (ue_s < 0);
        big_o    = (ue_s >= TOP_S);
        at_min_o = (ue_s == TOP_S) && (frac_i == '0);
        mag_o    = '0;
        if (!tiny_o && !big_o) begin
            if (ue_s >= FR_S)
                mag_o = sig_w << (ue_s - FR_S);
            else
                mag_o = sig_w >> (FR_S - ue_s);
        end
    end
endmodule

// File: rtl/f2i_negate.sv
module f2i_negate #(
    parameter int W = 32
) (
    input  logic         neg_i,
    input  logic [W-1:0] mag_i,
    output logic [W-1:0] val_o
);
    always_comb val_o = neg_i ? (~mag_i + W'(1)) : mag_i;
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_vld,
    output logic [INT_W-1:0]  out_int,
    output logic              out_nan,
    output logic              out_inf,
    output logic              out_ovf
);
    localparam logic [INT_W-1:0] MIN_V = {1'b1, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] val;
        logic             nan;
        logic             inf;
        logic             ovf;
    } res_t;

    res_t res_d, res_q;

    logic              sgn;
    logic [EXP_W-1:0]  expf;
    logic [FRAC_W-1:0] frac;
    fp_class_e         cls;
    logic [INT_W-1:0]  mag, sval;
    logic              tiny, big, at_min;

    f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .word_i(in_word), .sign_o(sgn), .exp_o(expf), .frac_o(frac), .cls_o(cls)
    );

    f2i_magnitude #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_mag (
        .exp_i(expf), .frac_i(frac), .mag_o(mag),
        .tiny_o(tiny), .big_o(big), .at_min_o(at_min)
    );

    f2i_negate #(.W(INT_W)) u_neg (.neg_i(sgn), .mag_i(mag), .val_o(sval));

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_vld;
        if (in_vld) begin
            res_d.val = '0;
            res_d.nan = 1'b0;
            res_d.inf = 1'b0;
            res_d.ovf = 1'b0;
            unique case (cls)
                FC_SUB: begin end
                FC_INF: begin
                    res_d.inf = 1'b1;
                    res_d.val = MIN_V;
                end
                FC_NAN: begin
                    res_d.nan = 1'b1;
                    res_d.val = MIN_V;
                end
                default: begin
                    if (big) begin
                        res_d.val = MIN_V;
                        res_d.ovf = !(sgn && at_min);
                    end else if (!tiny) begin
                        res_d.val = sval;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q.vld <= 1'b0;
        else
            res_q <= res_d;
    end

    assign out_vld = res_q.vld;
    assign out_int = res_q.val;
    assign out_nan = res_q.nan;
    assign out_inf = res_q.inf;
    assign out_ovf = res_q.ovf;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R6 R7 R8
    flag_min_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && (out_nan || out_inf || out_ovf)) |-> (out_int == MIN_V));
    // R9
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $onehot0({out_nan, out_inf, out_ovf}));
    // R3
    zero_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_word[FRAC_W +: EXP_W] == '0) |=>
        (out_int == '0 && !out_nan && !out_inf && !out_ovf));
    // R5
    pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_word[WORD_W-1] && in_word[FRAC_W +: EXP_W] != '1) |=>
        (!out_int[INT_W-1] || out_ovf));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_int) && $stable({out_nan, out_inf, out_ovf})));
endmodule

// File: tb/sim_f2i_conv.sv
module sim_f2i_conv;
    typedef struct {
        logic [31:0] val;
        logic        nan, inf, ovf;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_vld;
    logic [31:0] out_int;
    logic        out_nan, out_inf, out_ovf;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    item_t sb[$];
    item_t last;

    always #4 clk = ~clk;   // 125 MHz

    f2i_conv u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
        .out_vld(out_vld), .out_int(out_int),
        .out_nan(out_nan), .out_inf(out_inf), .out_ovf(out_ovf)
    );

    // Reference: 64-bit integer arithmetic built from the requirements.
    function automatic item_t model(input logic [31:0] w, input string tag);
        item_t       it;
        logic        s = w[31];
        int          e = int'(w[30:23]);
        logic [22:0] f = w[22:0];
        logic [63:0] m;
        it.tag = tag; it.val = 32'd0; it.nan = 0; it.inf = 0; it.ovf = 0;
        if (e == 255) begin
            it.val = 32'h8000_0000;
            it.nan = (f != 0);
            it.inf = (f == 0);
        end else if (e >= 127) begin
            if (e - 127 >= 32) begin
                it.val = 32'h8000_0000; it.ovf = 1;
            end else begin
                m = ({40'd0, 1'b1, f} << (e - 127)) >> 23;
                if ((!s && m > 64'h7FFF_FFFF) || (s && m > 64'h8000_0000)) begin
                    it.val = 32'h8000_0000; it.ovf = 1;
                end else begin
                    it.val = s ? 32'(64'd0 - m) : m[31:0];
                end
            end
        end
        return it;
    endfunction

    task automatic fail_line(input string tag, input string what,
                             input logic [34:0] act, input logic [34:0] exp);
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic send(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_vld  = 1'b1;
        in_word = w;
        sb.push_back(model(w, tag));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // Monitor: compares each result against the front of the scoreboard.
    always @(negedge clk) begin
        if (!rst && out_vld) begin
            n_chk++;
            if (sb.size() == 0) begin
                fail_line("R2", "unexpected out_vld", 35'd1, 35'd0);
            end else begin
                last = sb.pop_front();
                if (out_int !== last.val || out_nan !== last.nan ||
                    out_inf !== last.inf || out_ovf !== last.ovf)
                    fail_line(last.tag, "result {nan,inf,ovf,int}",
                              {out_nan, out_inf, out_ovf, out_int},
                              {last.nan, last.inf, last.ovf, last.val});
            end
        end
    end

    initial begin
        // R2: strobe during reset must not produce a result
        in_vld = 1'b1; in_word = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_vld !== 1'b0) fail_line("R2", "out_vld in reset", {34'd0, out_vld}, 35'd0);
        in_vld = 1'b0;
        rst = 1'b0;
        idle(2);
        n_chk++;
        if (out_vld !== 1'b0) fail_line("R2", "out_vld after reset", {34'd0, out_vld}, 35'd0);

        send(32'h466D_B400, "R1");   // 15213.0
        send(32'h3F80_0000, "R1");   // 1.0
        send(32'h4070_0000, "R1");   // 3.75 -> 3
        send(32'h4B80_0001, "R1");   // 2^24 + 2
        send(32'hBF80_0000, "R5");   // -1.0
        send(32'hC070_0000, "R5");   // -3.75 -> -3
        send(32'hC66D_B400, "R5");   // -15213.0
        send(32'h0000_0000, "R3");   // +0
        send(32'h8000_0000, "R3");   // -0
        send(32'h0000_0001, "R3");   // smallest subnormal
        send(32'h807F_FFFF, "R3");   // largest negative subnormal
        send(32'h3F00_0000, "R4");   // 0.5
        send(32'hBF7F_FFFF, "R4");   // just above -1
        send(32'h7F80_0000, "R6");   // +inf
        send(32'hFF80_0000, "R6");   // -inf
        send(32'h7FC0_0000, "R7");   // quiet NaN
        send(32'hFF80_0001, "R7");   // NaN, minimal fraction
        send(32'h4F00_0000, "R8");   // 2^31
        send(32'hCF00_0000, "R8");   // -2^31 exact
        send(32'h4EFF_FFFF, "R8");   // largest below 2^31
        send(32'hCF00_0001, "R8");   // just below -2^31
        send(32'h7F7F_FFFF, "R8");   // largest finite
        send(32'h7FC0_0000, "R9");   // NaN: only one flag
        send(32'h4F80_0000, "R9");   // 2^32: only ovf

        // R10: result holds across idle cycles
        send(32'h4228_0000, "R10");  // 42.0
        idle(4);
        n_chk++;
        if (out_vld !== 1'b0 || out_int !== 32'd42 || out_ovf !== 1'b0)
            fail_line("R10", "held result", {2'b0, out_vld, out_int}, {3'b0, 32'd42});

        // Pseudo-random sweep, half with exponents near the range edge
        begin
            logic [31:0] r = 32'hACE1_1234;
            for (int k = 0; k < 300; k++) begin
                logic [31:0] w;
                r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
                w = r;
                if (k % 2 == 1) w[30:23] = 8'd120 + {3'd0, r[4:0]} + {7'd0, r[5]} * 8'd8;
                send(w, (w[31] ? "R5" : "R1"));
                if (k % 7 == 3) idle(1);
            end
        end
        idle(3);
        n_chk++;
        if (sb.size() != 0) fail_line("R2", "missing results", 35'(sb.size()), 35'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            fail_line("R2", "watchdog expired", 35'd1, 35'd0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule